// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Pool

This block keeps a small set of waiting slots for instructions bound to one kind of functional unit. When an instruction is issued, the pool takes a free slot. For each of its two source operands it stores either the value itself or the tag of the unit that will produce that value. The pool then watches one shared result bus, which carries a tag and a value. Any waiting operand whose stored tag equals the tag on the bus takes the value and marks itself present. A single bus write can therefore wake every consumer of that result at once.

A slot whose two operands are both present asks to execute. Program order plays no part in this. When several slots are ready together, the lowest-numbered one goes first, and each slot is launched only once. A slot stays occupied until its own result appears on the bus, and only then is it returned to the free set. When every slot is occupied, the pool drops its issue-ready output so that in-order issue upstream stalls. If a producer broadcasts in the same cycle that its consumer is issued, the value is taken straight from the bus.

Top module: `rs_pool`

## Requirements
- R1: After reset every slot is free, `iss_ready` is 1, `fire_valid` is 0 and `iss_tag` shows the tag of slot 0.
- R2: A source presented with tag 0 is treated as a value: the value on the issue port is stored, and it later appears unchanged on the matching fire operand.
- R3: `fire_valid` is raised for a slot only while both of its stored tags are 0. `fire_opa` and `fire_opb` carry the slot's first and second operand values.
- R4: When `bus_valid` is 1, every waiting operand in every slot whose tag equals `bus_tag` stores `bus_val` and clears its tag, all in the same cycle. This includes both operands of one slot.
- R5: When an issued source tag equals `bus_tag` while `bus_valid` is 1 in the issue cycle, the slot stores `bus_val` as a present operand instead of the tag.
- R6: An operand stored as a value at issue is not changed by later broadcasts or later issues.
- R7: A slot stays occupied from issue until a broadcast carries its own tag, even after it has fired. `iss_ready` is 0 exactly while all slots are occupied, and `iss_tag` names the lowest-numbered free slot.
- R8: When several slots are ready in one cycle, the slot with the lowest index fires, and at most one slot fires per cycle.
- R9: Each issued slot fires exactly once.
- R10: The tag of slot i is (POOL_ID << log2(NUM_ENT)) + i. It is never zero, and it is given on `fire_tag` and `iss_tag`. With the defaults, the tags are 4 to 7.
- R11: An issue request made while `iss_ready` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | At least one slot is free |
| iss_tag | output | TAG_W | Tag the next issued instruction receives |
| iss_src1_tag | input | TAG_W | Producer tag of source 1 (0 = value present) |
| iss_src1_val | input | DATA_W | Value of source 1 |
| iss_src2_tag | input | TAG_W | Producer tag of source 2 (0 = value present) |
| iss_src2_val | input | DATA_W | Value of source 2 |
| bus_valid | input | 1 | Result broadcast valid |
| bus_tag | input | TAG_W | Tag of broadcast result |
| bus_val | input | DATA_W | Broadcast result value |
| fire_valid | output | 1 | A slot is launched this cycle |
| fire_tag | output | TAG_W | Tag of launched slot |
| fire_opa | output | DATA_W | First operand of launched slot |
| fire_opb | output | DATA_W | Second operand of launched slot |

## Verification
On every cycle, assertions check the following. A launch happens only for a slot with both tags clear that has not launched before. An occupied slot stays occupied until its own tag is broadcast. A snoop hit clears the tag and stores the bus value. At most one slot launches per cycle, and only a ready one. Other behaviours appear only as values seen at the ports, so only the bench's scenarios can show them. These are the same-cycle bypass at issue, the wake-up of several consumers by one broadcast, the lowest-index order among slots that become ready together, the preservation of values captured at issue, and the refusal of issue while the pool is full.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } slot_st_e;
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) gnt = N'(1) << i;
    end
  end
endmodule

// File: rtl/rs_slot.sv
module rs_slot
  import rs_pool_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter logic [TAG_W-1:0] MY_TAG = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [TAG_W-1:0]  src1_tag,
  input  logic [DATA_W-1:0] src1_val,
  input  logic [TAG_W-1:0]  src2_tag,
  input  logic [DATA_W-1:0] src2_val,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_val,
  input  logic              fire_me,
  output logic              busy,
  output logic              ready,
  output logic [DATA_W-1:0] opa,
  output logic [DATA_W-1:0] opb
);
  slot_st_e          st, st_n;
  logic [TAG_W-1:0]  qj, qj_n, qk, qk_n;
  logic [DATA_W-1:0] vj, vj_n, vk, vk_n;
  logic              upd;

  function automatic logic [TAG_W+DATA_W-1:0] take_src(
      input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] v,
      input logic bv, input logic [TAG_W-1:0] bt, input logic [DATA_W-1:0] bval);
    if (t == '0)             return {{TAG_W{1'b0}}, v};
    else if (bv && bt == t)  return {{TAG_W{1'b0}}, bval};
    else                     return {t, v};
  endfunction

  always_comb begin
    st_n = st; qj_n = qj; vj_n = vj; qk_n = qk; vk_n = vk;
    if (alloc) begin
      st_n = ST_WAIT;
      {qj_n, vj_n} = take_src(src1_tag, src1_val, bus_valid, bus_tag, bus_val);
      {qk_n, vk_n} = take_src(src2_tag, src2_val, bus_valid, bus_tag, bus_val);
    end else if (st != ST_FREE) begin
      if (bus_valid && qj != '0 && bus_tag == qj) begin qj_n = '0; vj_n = bus_val; end
      if (bus_valid && qk != '0 && bus_tag == qk) begin qk_n = '0; vk_n = bus_val; end
      if (fire_me) st_n = ST_RUN;
      if (bus_valid && bus_tag == MY_TAG) st_n = ST_FREE;
    end
  end

  assign upd = alloc | bus_valid | fire_me;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_FREE; qj <= '0; qk <= '0; vj <= '0; vk <= '0;
    end else if (upd) begin
      st <= st_n; qj <= qj_n; qk <= qk_n; vj <= vj_n; vk <= vk_n;
    end
  end

  assign busy  = (st != ST_FREE);
  assign ready = (st == ST_WAIT) && (qj == '0) && (qk == '0);
  assign opa   = vj;
  assign opb   = vk;

  // R3
  fire_tags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_me |-> (qj == '0 && qk == '0));
  // R9
  no_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_me |-> (st == ST_WAIT));
  // R7
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_FREE && !(bus_valid && bus_tag == MY_TAG)) |=> (st != ST_FREE));
  // R4
  snoop_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_FREE && !alloc && qj != '0 && bus_valid && bus_tag == qj)
      |=> (qj == '0 && vj == $past(bus_val)));
  // R4
  snoop_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_FREE && !alloc && qk != '0 && bus_valid && bus_tag == qk)
      |=> (qk == '0 && vk == $past(bus_val)));
endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int NUM_ENT = 4,
  parameter int DATA_W  = 32,
  parameter int POOL_W  = 2,
  parameter int POOL_ID = 1,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int TAG_W  = POOL_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic [TAG_W-1:0]  iss_src1_tag,
  input  logic [DATA_W-1:0] iss_src1_val,
  input  logic [TAG_W-1:0]  iss_src2_tag,
  input  logic [DATA_W-1:0] iss_src2_val,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_val,
  output logic              fire_valid,
  output logic [TAG_W-1:0]  fire_tag,
  output logic [DATA_W-1:0] fire_opa,
  output logic [DATA_W-1:0] fire_opb
);
  logic [NUM_ENT-1:0] busy_vec, ready_vec, free_gnt, fire_vec, alloc_vec;
  logic [TAG_W-1:0]   etag [NUM_ENT];
  logic [DATA_W-1:0]  opa_a [NUM_ENT];
  logic [DATA_W-1:0]  opb_a [NUM_ENT];

  rs_pick #(.N(NUM_ENT)) u_free_pick (.req(~busy_vec), .gnt(free_gnt));
  rs_pick #(.N(NUM_ENT)) u_fire_pick (.req(ready_vec), .gnt(fire_vec));

  assign iss_ready = ~&busy_vec;
  assign alloc_vec = free_gnt & {NUM_ENT{iss_valid}};

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_slot
    localparam logic [TAG_W-1:0] ETAG = TAG_W'((POOL_ID << IDX_W) + i);
    assign etag[i] = ETAG;
    rs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W), .MY_TAG(ETAG)) u_slot (
      .clk(clk), .rst_n(rst_n), .alloc(alloc_vec[i]),
      .src1_tag(iss_src1_tag), .src1_val(iss_src1_val),
      .src2_tag(iss_src2_tag), .src2_val(iss_src2_val),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_val),
      .fire_me(fire_vec[i]), .busy(busy_vec[i]), .ready(ready_vec[i]),
      .opa(opa_a[i]), .opb(opb_a[i]));
  end

  always_comb begin
    iss_tag  = '0;
    fire_tag = '0;
    fire_opa = '0;
    fire_opb = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (free_gnt[i]) iss_tag = etag[i];
      if (fire_vec[i]) begin
        fire_tag = etag[i];
        fire_opa = opa_a[i];
        fire_opb = opb_a[i];
      end
    end
  end

  assign fire_valid = |fire_vec;

  // R8
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire_vec));
  // R8
  fire_is_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_vec & ~ready_vec) == '0);
  // R11
  full_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy_vec) |-> (alloc_vec == '0));
endmodule

// File: tb/sim_rs_pool.sv
module sim_rs_pool;
  logic        clk, rst_n;
  logic        iss_valid, iss_ready, bus_valid, fire_valid;
  logic [3:0]  iss_tag, iss_src1_tag, iss_src2_tag, bus_tag, fire_tag;
  logic [31:0] iss_src1_val, iss_src2_val, bus_val, fire_opa, fire_opb;

  typedef struct {
    logic [3:0]  t;
    logic [31:0] a;
    logic [31:0] b;
    string       req;
  } exp_t;
  exp_t expq[$];

  int n_run = 0, n_fail = 0;
  bit done = 0;

  rs_pool u0 (.*);

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [99:0] act, input logic [99:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] t, input logic [31:0] a, input logic [31:0] b, input string req);
    exp_t e;
    e.t = t; e.a = a; e.b = b; e.req = req;
    expq.push_back(e);
  endtask

  task automatic drive(input bit iv, input logic [3:0] t1, input logic [31:0] v1,
                       input logic [3:0] t2, input logic [31:0] v2,
                       input bit bv, input logic [3:0] bt, input logic [31:0] bval);
    iss_valid = iv; iss_src1_tag = t1; iss_src1_val = v1;
    iss_src2_tag = t2; iss_src2_val = v2;
    bus_valid = bv; bus_tag = bt; bus_val = bval;
    @(negedge clk);
    iss_valid = 0; bus_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: every launch is compared with the next expected item
  always @(negedge clk) begin
    if (rst_n && fire_valid) begin
      if (expq.size() == 0) begin
        chk(0, "R9 unexpected launch", {fire_tag, fire_opa, fire_opb}, 100'h0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(fire_tag == e.t && fire_opa == e.a && fire_opb == e.b, e.req,
            {fire_tag, fire_opa, fire_opb}, {e.t, e.a, e.b});
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; iss_valid = 0; bus_valid = 0;
    iss_src1_tag = 0; iss_src2_tag = 0; iss_src1_val = 0; iss_src2_val = 0;
    bus_tag = 0; bus_val = 0;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state, R10 slot 0 tag
    chk(iss_ready == 1, "R1 iss_ready", 100'(iss_ready), 100'd1);
    chk(fire_valid == 0, "R1 fire_valid", 100'(fire_valid), 100'd0);
    chk(iss_tag == 4'd4, "R10 iss_tag slot0", 100'(iss_tag), 100'd4);

    // R2 both operands present at issue
    push(4'd4, 32'd10, 32'd20, "R2");
    drive(1, 0, 32'd10, 0, 32'd20, 0, 0, 0);
    chk(iss_tag == 4'd5, "R7 next free tag", 100'(iss_tag), 100'd5);

    // fill the pool with waiting slots
    drive(1, 4'd9, 0, 0, 32'd7, 0, 0, 0);          // slot1 tag5
    drive(1, 4'd9, 0, 4'd10, 0, 0, 0, 0);          // slot2 tag6
    drive(1, 0, 32'd3, 4'd9, 0, 0, 0, 0);          // slot3 tag7, R6 value 3
    chk(iss_ready == 0, "R7 full pool", 100'(iss_ready), 100'd0);
    // R11 request while full must be dropped
    drive(1, 0, 32'hDEAD, 0, 32'hBEEF, 0, 0, 0);
    idle(2);

    // R4 one broadcast wakes slots 1,2(j),3; R8 slot1 before slot3; R6 value kept
    push(4'd5, 32'd100, 32'd7, "R4");
    push(4'd7, 32'd3, 32'd100, "R8 R6");
    drive(0, 0, 0, 0, 0, 1, 4'd9, 32'd100);
    idle(2);
    push(4'd6, 32'd100, 32'd55, "R4");
    drive(0, 0, 0, 0, 0, 1, 4'd10, 32'd55);
    idle(2);
    chk(iss_ready == 0, "R7 busy after fire", 100'(iss_ready), 100'd0);

    // R7 own-tag broadcast frees slot
    drive(0, 0, 0, 0, 0, 1, 4'd4, 32'd1);
    chk(iss_ready == 1 && iss_tag == 4'd4, "R7 slot0 freed", {iss_ready, iss_tag}, {1'b1, 4'd4});
    drive(0, 0, 0, 0, 0, 1, 4'd5, 32'd1);
    drive(0, 0, 0, 0, 0, 1, 4'd6, 32'd1);
    drive(0, 0, 0, 0, 0, 1, 4'd7, 32'd1);
    chk(iss_tag == 4'd4 && iss_ready == 1, "R11 no stray slot", {iss_ready, iss_tag}, {1'b1, 4'd4});

    // R5 bypass: producer broadcasts in issue cycle
    push(4'd4, 32'd77, 32'd1, "R5");
    drive(1, 4'd11, 32'd0, 0, 32'd1, 1, 4'd11, 32'd77);
    idle(1);

    // R4 both operands of one slot woken by a single broadcast
    push(4'd5, 32'd5, 32'd5, "R4 both");
    drive(1, 4'd12, 0, 4'd12, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 1, 4'd12, 32'd5);
    idle(6);

    // R9 every expected launch seen, none twice
    chk(expq.size() == 0, "R9 pending launches", 100'(expq.size()), 100'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule